// File: doc/BRIEF.md
# Boot-Loaded Lookup-Table Address Decoder

This block decodes a processor address into a vector of chip-select lines. The decoding is not fixed logic: each select pattern comes from a writable lookup table indexed by the upper bits of the processor address. Because the map lives in RAM, a different memory layout needs only a different table image in the nonvolatile store. Fixed gates are not involved.

After reset a loader sequencer holds the processor in reset. It presents every table index in turn to a nonvolatile read port and writes each returned entry into the table RAM. When the last entry is written, a settle timer runs for a fixed number of clocks. The sequencer then switches itself off, raises the ready flag and releases the processor. From that point the table is read-only and its output for the current address drives the selects until the next reset.

The sequencer has four named states:
- `ST_LOAD` presents indices to the nonvolatile port.
- `ST_FLUSH` spends one clock writing the final entry.
- `ST_SETTLE` counts the settle interval.
- `ST_RUN` is normal operation.

Its transitions are:
- `ST_LOAD` to `ST_FLUSH` on the last index.
- `ST_FLUSH` to `ST_SETTLE` unconditionally.
- `ST_SETTLE` to `ST_RUN` when the timer expires.
- Any state to `ST_LOAD` on reset.

Top module: `lut_addr_decoder`

## Requirements
- R1: While `rst` is high and until `ready` rises, `cpu_reset` is 1, `ready` is 0 and every bit of `cs_n` is 1 (no line selected).
- R2: From the clock edge after `rst` falls, `nv_idx` starts at 0 and increases by one each clock, visiting every table index 0 to 2^IDX_W-1 exactly once.
- R3: The nonvolatile port returns, on `nv_data`, the entry for an index one clock after that index appears on `nv_idx`. The table entry at that index is loaded with that returned value.
- R4: `ready` is first seen high after exactly 2^IDX_W + 1 + SETTLE rising edges following the release of `rst`. At that point `cpu_reset` falls, and the last SETTLE of those edges follow the write of the final entry.
- R5: While `ready` is high, `cs_n` equals the table entry at index `cpu_addr[ADDR_W-1 -: IDX_W]`. This output is combinational in `cpu_addr`.
- R6: Each table entry is SEL_W bits wide. Bit i of the entry drives `cs_n[i]`, and a 0 bit selects line i (active low).
- R7: Once `ready` is high, values on `nv_data` no longer change the table, and `ready` stays high until `rst` is asserted again.
- R8: Asserting `rst` at any time restarts the full load. After release, a new image is loaded and decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | ADDR_W | Processor address bus |
| nv_data | input | SEL_W | Read data from the nonvolatile table store, one clock after `nv_idx` |
| nv_idx | output | IDX_W | Table index presented to the nonvolatile store during loading |
| cpu_reset | output | 1 | Processor reset, active high, held during load and settle |
| cs_n | output | SEL_W | Active-low chip selects |
| ready | output | 1 | High once the table is loaded and the processor is released |

## Verification
The bench builds the decoder with ADDR_W=10, IDX_W=8 and SEL_W=8, keeping the default SETTLE of 16. This makes a load take only 273 clocks. It also makes it practical to sweep every one of the 1024 processor addresses against an arithmetically generated image, after each load and after the ignored-write window. Reloading with a second image after a reset shows that no entry survives from the first load. The edge-exact count of the load and settle phases confirms the timer length.

// File: rtl/lutdec_pkg.sv
package lutdec_pkg;
    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_FLUSH  = 2'd1,
        ST_SETTLE = 2'd2,
        ST_RUN    = 2'd3
    } ld_state_t;
endpackage

// File: rtl/lut_load_seq.sv
module lut_load_seq
    import lutdec_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int SETTLE = 16
) (
    input  logic             clk,
    input  logic             rst,
    output logic [IDX_W-1:0] nv_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output ld_state_t        state
);
    localparam int TW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};
    localparam logic [TW-1:0]    TMR_END  = TW'(SETTLE - 1);

    ld_state_t        state_nx;
    logic [IDX_W-1:0] cnt;
    logic [TW-1:0]    tmr;

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOAD:   if (cnt == LAST_IDX) state_nx = ST_FLUSH;
            ST_FLUSH:  state_nx = ST_SETTLE;
            ST_SETTLE: if (tmr == TMR_END) state_nx = ST_RUN;
            ST_RUN:    state_nx = ST_RUN;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_LOAD;
            cnt    <= '0;
            tmr    <= '0;
            wr_en  <= 1'b0;
            wr_idx <= '0;
        end else begin
            state  <= state_nx;
            wr_en  <= (state == ST_LOAD);
            wr_idx <= cnt;
            if (state == ST_LOAD && cnt != LAST_IDX)
                cnt <= cnt + 1'b1;
            if (state == ST_SETTLE)
                tmr <= tmr + 1'b1;
            else
                tmr <= '0;
        end
    end

    assign nv_idx = cnt;

    // R2
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD && cnt != LAST_IDX) |=> (nv_idx == $past(nv_idx) + 1'b1));

    // R7
    no_late_write_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> !wr_en);

    // R3
    write_lag_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD) |=> (wr_en && wr_idx == $past(nv_idx)));
endmodule

// File: rtl/lut_table_ram.sv
module lut_table_ram #(
    parameter int IDX_W = 10,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [DW-1:0]    rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[widx] <= wdata;
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/lut_addr_decoder.sv
module lut_addr_decoder
    import lutdec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 10,
    parameter int SEL_W  = 8,
    parameter int SETTLE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [SEL_W-1:0]  nv_data,
    output logic [IDX_W-1:0]  nv_idx,
    output logic              cpu_reset,
    output logic [SEL_W-1:0]  cs_n,
    output logic              ready
);
    ld_state_t        state;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [SEL_W-1:0] rd_data;

    lut_load_seq #(.IDX_W(IDX_W), .SETTLE(SETTLE)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .nv_idx (nv_idx),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .state  (state)
    );

    assign rd_idx = cpu_addr[ADDR_W-1 -: IDX_W];

    lut_table_ram #(.IDX_W(IDX_W), .DW(SEL_W)) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .widx  (wr_idx),
        .wdata (nv_data),
        .ridx  (rd_idx),
        .rdata (rd_data)
    );

    // output process driven by the sequencer state
    always_comb begin
        unique case (state)
            ST_RUN: begin
                ready     = 1'b1;
                cpu_reset = 1'b0;
                cs_n      = rd_data;
            end
            default: begin
                ready     = 1'b0;
                cpu_reset = 1'b1;
                cs_n      = '1;
            end
        endcase
    end

    // R1
    idle_sel_chk: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (cpu_reset && cs_n == '1));

    // R7
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    // R4
    release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $fell(cpu_reset));
endmodule

// File: tb/sim_lut_addr_decoder.sv
`timescale 1ns/1ps
module sim_lut_addr_decoder;
    localparam int ADDR_W = 10;
    localparam int IDX_W  = 8;
    localparam int SEL_W  = 8;
    localparam int SETTLE = 16;
    localparam int N      = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [SEL_W-1:0]  nv_data = '0;
    logic [IDX_W-1:0]  nv_idx;
    logic              cpu_reset;
    logic [SEL_W-1:0]  cs_n;
    logic              ready;

    int checks = 0;
    int errors = 0;
    int seed   = 1;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lut_addr_decoder #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEL_W(SEL_W), .SETTLE(SETTLE)) u0 (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .nv_data(nv_data),
        .nv_idx(nv_idx), .cpu_reset(cpu_reset), .cs_n(cs_n), .ready(ready)
    );

    function automatic logic [SEL_W-1:0] image(input int idx, input int s);
        return SEL_W'(((idx * 29) + (s * 71) + (idx >> 3)) ^ (s * 13));
    endfunction

    // nonvolatile store model: one clock read latency (R3)
    always @(posedge clk) nv_data <= image(int'(nv_idx), seed);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // load with the current seed, checking walk and timing
    task automatic do_load();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset cpu_reset", 32'(cpu_reset), 1);
        chk("R1 reset ready", 32'(ready), 0);
        chk("R1 reset cs_n", 32'(cs_n), 32'(8'hFF));
        rst = 1'b0;
        for (int k = 0; k < N; k++) begin
            chk("R2 nv_idx walk", 32'(nv_idx), 32'(k));
            chk("R1 load cs_n", 32'(cs_n), 32'(8'hFF));
            @(negedge clk);
        end
        for (int k = 0; k < SETTLE; k++) begin
            @(negedge clk);
            chk("R4 not ready during settle", 32'(ready), 0);
            chk("R4 cpu_reset during settle", 32'(cpu_reset), 1);
        end
        @(negedge clk);
        chk("R4 ready after settle", 32'(ready), 1);
        chk("R4 cpu_reset released", 32'(cpu_reset), 0);
    endtask

    task automatic sweep(input int s, input string req);
        for (int a = 0; a < (1 << ADDR_W); a++) begin
            cpu_addr = ADDR_W'(a);
            #1;
            chk(req, 32'(cs_n), 32'(image(a >> (ADDR_W - IDX_W), s)));
        end
    endtask

    initial begin
        // first image
        seed = 1;
        do_load();
        sweep(1, "R5 R3 decode image1");
        // R6: entry 0 bit pattern drives lines directly, 0 = selected
        cpu_addr = '0;
        #1;
        for (int b = 0; b < SEL_W; b++)
            chk("R6 line polarity", 32'(cs_n[b]), 32'(image(0, 1) >> b) & 1);
        // R7: store changes after ready are ignored
        seed = 5;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (k % 50 == 0) chk("R7 ready held", 32'(ready), 1);
        end
        sweep(1, "R7 table unchanged");
        // R8: reset mid-run reloads a different image
        do_load();
        sweep(5, "R8 reload image2");
        // R8: reset during load restarts from index 0
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (40) @(negedge clk);
        chk("R8 load in progress", 32'(ready), 0);
        seed = 9;
        do_load();
        sweep(9, "R8 reload image3");
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule